// File: doc/BRIEF.md
# Multichannel ADC Limit Monitor

This block watches a stream of ADC results on eight monitor channels. Each channel owns an eight-byte register bank. The bank chooses which ADC source the channel follows, a 16-bit lower and upper limit, one of three shared interval timers, and which interrupts it raises. When a channel's interval timer expires, the block sends a one-cycle conversion request for that channel. This arms the channel. The next sample that comes back tagged with the channel's source is compared against both limits. A sample outside the limits sets a sticky status bit. Status is kept in two bitmaps, one for readings below the lower limit and one for readings above the upper limit. A single interrupt line gathers all the enabled status bits.

Software reaches everything through a byte-wide register port. Writes take effect on the clock edge. Reads are combinational from the address. Samples arrive on a valid/ready stream. The monitor never applies back-pressure: ready is held high after reset, and a sample is consumed in every cycle where valid is high. A sample that no armed channel is waiting for is dropped.

Top module: `adc_limit_monitor`

## Requirements
- R1: After reset the status bitmaps at 0x0a and 0x0b read 0, irq and every conv_req bit are 0, and the read-only byte at 0x0f reads 8, the number of channels.
- R2: Channel n's bank starts at 0x60+8n. The byte offsets are: 0 source select, 1 lower limit low byte, 2 lower limit high byte, 3 upper limit low byte, 4 upper limit high byte, 5 timer select (bits 1:0), 6 control (settle code in bits 3:0, calibration select in bits 5:4, kept for readback), 7 enable. Every bank byte reads back the value written.
- R3: Timers count and requests are issued only while bit 7 of 0x46 (run enable) and bit 7 of 0x47 (request enable) are both 1. With either bit clear, no conv_req is issued.
- R4: Each timer expires every (code+1)*TICK_SCALE cycles. Timer 0 takes its code from 0x44, timer 1 from bits 7:4 of 0x45, and timer 2 from bits 3:0 of 0x45.
- R5: On each expiry, conv_req[n] pulses for one cycle for every channel with measurement enable (enable bit 7) set whose timer select equals that timer. Timer select 3 never requests.
- R6: A request arms its channel. The next accepted sample whose source tag equals bank byte 0 is compared, and this disarms the channel. A sample with a different tag, or one arriving while the channel is not armed, changes no status.
- R7: A compared sample strictly below the lower limit sets bit n of 0x0a. A sample strictly above the upper limit sets bit n of 0x0b. A sample equal to a limit sets neither. When the lower limit is above the upper limit, a single sample can set both bits.
- R8: Status bits are sticky. A later in-range sample leaves them set. They clear only on a write to any byte of that channel's bank, and such a write also disarms the channel. Writes to 0x0a, 0x0b and 0x0f have no effect.
- R9: irq is high exactly when some channel has measurement enable set and either its low status bit with enable bit 0 set, or its high status bit with enable bit 1 set.
- R10: smp_ready is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, always high after reset |
| smp_src | input | 8 | ADC source tag of the sample |
| smp_data | input | 16 | ADC result |
| conv_req | output | 8 | Per-channel conversion request pulse |
| irq | output | 1 | Combined interrupt |

## Verification
A table of limit pairs and sample values drives channel 0 through several cases: below the lower limit, equal to each limit, strictly between the limits, above the upper limit, and an inverted pair where one sample sets both bits. Together these separate strict from inclusive comparison and show that the two status bits are independent. Directed cases then check the following: a sample with the wrong tag or with no request pending is rejected; a sticky bit survives an in-range sample; a bank write clears status; a write to a status byte does nothing; the interrupt is gated by the enable bits. The interval between requests is measured on two different timers, which would expose a wrong code field or an off-by-one in the period.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;
  localparam logic [7:0] A_STAT_LO  = 8'h0a;
  localparam logic [7:0] A_STAT_HI  = 8'h0b;
  localparam logic [7:0] A_NUM_CH   = 8'h0f;
  localparam logic [7:0] A_TMR0     = 8'h44;
  localparam logic [7:0] A_TMR12    = 8'h45;
  localparam logic [7:0] A_RUN      = 8'h46;
  localparam logic [7:0] A_REQ      = 8'h47;
  localparam logic [7:0] A_BANK0    = 8'h60;
  localparam int         BANK_BYTES = 8;
  localparam int         NUM_TMR    = 3;
  localparam logic [1:0] TSEL_NONE  = 2'd3;
endpackage

// File: rtl/adc_mon_timer.sv
module adc_mon_timer #(
  parameter int TICK_SCALE = 1000,
  parameter int CODE_W     = 8,
  localparam int CNT_W     = $clog2(((1 << CODE_W) * TICK_SCALE) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // period is (code+1)*TICK_SCALE; wrap with >= so a shortened code takes effect at once
  assign last = CNT_W'((32'(code) + 32'd1) * 32'(TICK_SCALE) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_mon_channel.sv
module adc_mon_channel
  import adc_mon_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SRC_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         off,
  input  logic [7:0]         wdata,
  output logic [7:0]         rd_data,
  input  logic [NUM_TMR-1:0] tick,
  input  logic               run,
  input  logic               smp_fire,
  input  logic [SRC_W-1:0]   smp_src,
  input  logic [DATA_W-1:0]  smp_data,
  output logic               conv_req,
  output logic               stat_lo,
  output logic               stat_hi,
  output logic               int_req
);
  logic [7:0]        bank [BANK_BYTES];
  logic              armed;
  logic [SRC_W-1:0]  src_sel;
  logic [DATA_W-1:0] lim_lo, lim_hi;
  logic [1:0]        tsel;
  logic              meas_en, lo_ie, hi_ie, hit;
  logic [NUM_TMR:0]  tick_x;

  assign src_sel  = SRC_W'(bank[0]);
  assign lim_lo   = DATA_W'({bank[2], bank[1]});
  assign lim_hi   = DATA_W'({bank[4], bank[3]});
  assign tsel     = bank[5][1:0];
  assign meas_en  = bank[7][7];
  assign hi_ie    = bank[7][1];
  assign lo_ie    = bank[7][0];
  assign rd_data  = bank[off];
  assign tick_x   = {1'b0, tick};
  assign conv_req = run && meas_en && (tsel != TSEL_NONE) && tick_x[tsel];
  assign hit      = smp_fire && armed && (smp_src == src_sel);
  assign int_req  = meas_en && ((stat_lo && lo_ie) || (stat_hi && hi_ie));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BANK_BYTES; i++) bank[i] <= 8'h00;
    end else if (wr_en) begin
      bank[off] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      stat_lo <= 1'b0;
      stat_hi <= 1'b0;
    end else if (wr_en) begin
      armed   <= 1'b0;
      stat_lo <= 1'b0;
      stat_hi <= 1'b0;
    end else begin
      if (hit) begin
        if (smp_data < lim_lo) stat_lo <= 1'b1;
        if (smp_data > lim_hi) stat_hi <= 1'b1;
      end
      if (conv_req)  armed <= 1'b1;
      else if (hit)  armed <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_limit_monitor.sv
module adc_limit_monitor
  import adc_mon_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int DATA_W     = 16,
  parameter int SRC_W      = 8,
  parameter int TICK_SCALE = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SRC_W-1:0]  smp_src,
  input  logic [DATA_W-1:0] smp_data,
  output logic [NUM_CH-1:0] conv_req,
  output logic              irq
);
  localparam int         IDX_W    = $clog2(NUM_CH);
  localparam logic [8:0] BANK_END = 9'(A_BANK0) + 9'(NUM_CH * BANK_BYTES);

  logic [7:0]        tmr0_code, tmr12_code;
  logic              gen_en, req_en, run, in_bank, smp_fire;
  logic [7:0]        bank_rel;
  logic [IDX_W-1:0]  ch_idx;
  logic [NUM_CH-1:0] stat_lo, stat_hi, int_vec;
  logic [7:0]        ch_rd [NUM_CH];
  logic [NUM_TMR-1:0] tick;
  logic [7:0]        tmr_code [NUM_TMR];
  logic              rdy_q;

  assign run       = gen_en && req_en;
  assign in_bank   = ({1'b0, reg_addr} >= 9'(A_BANK0)) && ({1'b0, reg_addr} < BANK_END);
  assign bank_rel  = reg_addr - A_BANK0;
  assign ch_idx    = bank_rel[3 +: IDX_W];
  assign smp_ready = rdy_q;
  assign smp_fire  = smp_valid && rdy_q;
  assign irq       = |int_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr0_code  <= 8'h00;
      tmr12_code <= 8'h00;
      gen_en     <= 1'b0;
      req_en     <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (reg_we) begin
        unique case (reg_addr)
          A_TMR0:  tmr0_code  <= reg_wdata;
          A_TMR12: tmr12_code <= reg_wdata;
          A_RUN:   gen_en     <= reg_wdata[7];
          A_REQ:   req_en     <= reg_wdata[7];
          default: ;
        endcase
      end
    end
  end

  assign tmr_code[0] = tmr0_code;
  assign tmr_code[1] = {4'h0, tmr12_code[7:4]};
  assign tmr_code[2] = {4'h0, tmr12_code[3:0]};

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    adc_mon_timer #(.TICK_SCALE(TICK_SCALE), .CODE_W(8)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .code (tmr_code[t]),
      .tick (tick[t])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    adc_mon_channel #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we && in_bank && (ch_idx == IDX_W'(c))),
      .off     (reg_addr[2:0]),
      .wdata   (reg_wdata),
      .rd_data (ch_rd[c]),
      .tick    (tick),
      .run     (run),
      .smp_fire(smp_fire),
      .smp_src (smp_src),
      .smp_data(smp_data),
      .conv_req(conv_req[c]),
      .stat_lo (stat_lo[c]),
      .stat_hi (stat_hi[c]),
      .int_req (int_vec[c])
    );
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (in_bank) begin
      reg_rdata = ch_rd[ch_idx];
    end else begin
      unique case (reg_addr)
        A_STAT_LO: reg_rdata = 8'(stat_lo);
        A_STAT_HI: reg_rdata = 8'(stat_hi);
        A_NUM_CH:  reg_rdata = 8'(NUM_CH);
        A_TMR0:    reg_rdata = tmr0_code;
        A_TMR12:   reg_rdata = tmr12_code;
        A_RUN:     reg_rdata = {gen_en, 7'h00};
        A_REQ:     reg_rdata = {req_en, 7'h00};
        default:   reg_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/adc_mon_chk.sv
module adc_mon_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [7:0]        reg_addr,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              irq,
  input logic [NUM_CH-1:0] conv_req,
  input logic [NUM_CH-1:0] stat_lo,
  input logic [NUM_CH-1:0] stat_hi,
  input logic              gen_en,
  input logic              req_en
);
  logic       bank_wr;
  logic [2:0] wr_ch;
  assign bank_wr = reg_we && (reg_addr >= 8'h60) && (reg_addr < 8'ha0);
  assign wr_ch   = 3'((reg_addr - 8'h60) >> 3);

  AST_REQ_ONLY_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (|conv_req) |-> (gen_en && req_en)); // R3

  AST_STATUS_SET_BY_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|((stat_lo | stat_hi) & ~($past(stat_lo) | $past(stat_hi)))) |-> $past(smp_valid && smp_ready)); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(($past(stat_lo) & ~stat_lo) | ($past(stat_hi) & ~stat_hi))) |-> $past(reg_we)); // R8

  AST_BANK_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> (stat_lo[$past(wr_ch)] == 1'b0 && stat_hi[$past(wr_ch)] == 1'b0)); // R8

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_lo == '0 && stat_hi == '0) |-> !irq); // R9

  AST_READY_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> smp_ready); // R10
endmodule

bind adc_limit_monitor adc_mon_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .smp_valid(smp_valid),
  .smp_ready(smp_ready),
  .irq      (irq),
  .conv_req (conv_req),
  .stat_lo  (stat_lo),
  .stat_hi  (stat_hi),
  .gen_en   (gen_en),
  .req_en   (req_en)
);

// File: tb/tb_adc_limit_monitor.sv
module tb_adc_limit_monitor;
  localparam int SCALE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [7:0]  smp_src = 8'h00;
  logic [15:0] smp_data = 16'h0000;
  logic [7:0]  conv_req;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  adc_limit_monitor #(.TICK_SCALE(SCALE)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_src(smp_src), .smp_data(smp_data),
    .conv_req(conv_req), .irq(irq)
  );

  // {lower, upper, sample, exp_low_bit, exp_high_bit}
  localparam int NV = 6;
  localparam logic [49:0] VEC [NV] = '{
    {16'd100, 16'd200, 16'd99,  1'b1, 1'b0},
    {16'd100, 16'd200, 16'd100, 1'b0, 1'b0},
    {16'd100, 16'd200, 16'd150, 1'b0, 1'b0},
    {16'd100, 16'd200, 16'd200, 1'b0, 1'b0},
    {16'd100, 16'd200, 16'd201, 1'b0, 1'b1},
    {16'd300, 16'd50,  16'd120, 1'b1, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_req(input int ch);
    do @(negedge clk); while (!conv_req[ch]);
  endtask

  task automatic send(input logic [7:0] s, input logic [15:0] v);
    @(negedge clk);
    smp_src = s; smp_data = v; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic set_limits(input logic [15:0] lo, input logic [15:0] hi);
    wr(8'h61, lo[7:0]); wr(8'h62, lo[15:8]);
    wr(8'h63, hi[7:0]); wr(8'h64, hi[15:8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h0a, r); check("R1 low status", r, 0);
    rd(8'h0b, r); check("R1 high status", r, 0);
    rd(8'h0f, r); check("R1 channel count", r, 8);
    check("R1 irq", irq, 0);
    check("R1 conv_req", conv_req, 0);
    check("R10 ready", smp_ready, 1);

    // R2 bank readback for channel 3
    wr(8'h7e, 8'h25);
    rd(8'h7e, r); check("R2 ch3 control byte", r, 8'h25);
    rd(8'h76, r); check("R2 ch2 control untouched", r, 0);

    // channel 0: source 5, timer 0, measurement + both interrupts
    wr(8'h44, 8'd1);
    wr(8'h60, 8'd5);
    wr(8'h65, 8'd0);
    wr(8'h67, 8'h83);

    // R3 no requests until both enables set
    wr(8'h46, 8'h80);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (conv_req[0]) cnt++; end
    check("R3 no request with one enable", cnt, 0);
    wr(8'h47, 8'h80);

    // R6 R7 vector table
    for (int v = 0; v < NV; v++) begin
      set_limits(VEC[v][49:34], VEC[v][33:18]);
      wait_req(0);
      send(8'd5, VEC[v][17:2]);
      rd(8'h0a, r); check("R7 low bit", int'(r[0]), int'(VEC[v][1]));
      rd(8'h0b, r); check("R7 high bit", int'(r[0]), int'(VEC[v][0]));
    end

    // R8 sticky: set high, then in-range sample
    set_limits(16'd100, 16'd200);
    wait_req(0); send(8'd5, 16'd500);
    wait_req(0); send(8'd5, 16'd150);
    rd(8'h0b, r); check("R8 sticky high", int'(r[0]), 1);
    check("R9 irq high enabled", irq, 1);
    wr(8'h0b, 8'h00);
    rd(8'h0b, r); check("R8 status write ignored", int'(r[0]), 1);
    wr(8'h0f, 8'h03);
    rd(8'h0f, r); check("R8 count write ignored", r, 8);
    wr(8'h66, 8'h12);
    rd(8'h0b, r); check("R8 bank write clears", int'(r[0]), 0);
    check("R9 irq after clear", irq, 0);

    // R6 wrong source ignored
    wait_req(0); send(8'd6, 16'd10);
    rd(8'h0a, r); check("R6 wrong source", int'(r[0]), 0);

    // R6 no pending request ignored
    wr(8'h47, 8'h00);
    wr(8'h61, 8'd100);
    send(8'd5, 16'd10);
    rd(8'h0a, r); check("R6 unarmed sample", int'(r[0]), 0);
    wr(8'h47, 8'h80);

    // R9 interrupt gating: only high int enabled, low crossing
    wr(8'h67, 8'h82);
    wait_req(0); send(8'd5, 16'd10);
    rd(8'h0a, r); check("R9 low status set", int'(r[0]), 1);
    check("R9 irq masked", irq, 0);
    wr(8'h67, 8'h81);
    wait_req(0); send(8'd5, 16'd10);
    check("R9 irq low enabled", irq, 1);

    // R4 period of timer 0 with code 2 -> 3*SCALE
    wr(8'h44, 8'd2);
    wait_req(0);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!conv_req[0]);
    check("R4 timer0 period", cnt, 3 * SCALE);

    // R4 R5 channel 1 on timer 1 (0x45[7:4]=3) -> 4*SCALE
    wr(8'h45, 8'h31);
    wr(8'h6d, 8'd1);
    wr(8'h6f, 8'h80);
    wait_req(1);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!conv_req[1]);
    check("R4 timer1 period", cnt, 4 * SCALE);

    // R5 timer select 3 never requests
    wr(8'h6d, 8'd3);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (conv_req[1]) cnt++; end
    check("R5 select none", cnt, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule